// File: doc/BRIEF.md
# Memory Carveout Access Protection Checker

This block sits in the request path of a memory controller and judges every incoming request against two programmable protected windows. The first window admits only requests that carry the secure attribute. The second window is a display/video window that turns away requests coming from the CPU and lets every other memory client through. A request that is turned away never reaches memory. A read receives an error response instead. A write is silently discarded.

Software sets both windows through a small 32-bit register port. Each window has a byte base address and a size counted in whole megabytes, and a size of zero switches that window off. Every block sets a sticky status bit for the window that caused it and captures the faulting address. An interrupt line stays high while any status bit is set. Software clears the bits by writing ones to them.

The allow/deny decision is formed combinationally from the request and the current settings, then registered, so the outcome appears one cycle after the request.

Top module: `carveout_guard`

## Requirements
- R1: After reset, every configuration register, the status bits and the captured fault address are zero, `irq` is low, and `fwd_valid`, `blk_rd_err` and `blk_wr_drop` are low.
- R2: The registers are at these word offsets on `reg_addr`:
  - 0: secure window base, a 32-bit byte address.
  - 1: secure window size in MB. Only the low SIZE_W bits are kept, and the other bits read zero.
  - 2: video base, low 32 bits.
  - 3: video base, high 32 bits.
  - 4: video size in MB, with the same SIZE_W masking as offset 1.
  - 5: status. Bit 0 is the secure window and bit 1 is the video window.
  - 6: fault address, low 32 bits. Read-only.
  - 7: fault address, high bits. Read-only.
  - Offsets 8 to 15 read zero.
  - `reg_rdata` is combinational on `reg_addr`.
- R3: A request falls in a window when base <= address < base + size*2^20. A size of zero means the window matches nothing.
- R4: A request in the secure window that does not carry the secure attribute (`req_secure`=0) is blocked. A request that carries the secure attribute is not blocked by this window.
- R5: The video window base is {offset 3, offset 2}. A request with `req_cpu`=1 in the video window is blocked. A request with `req_cpu`=0 is not blocked by this window.
- R6: Every request with `req_valid`=1 produces, on the next cycle, exactly one of these results:
  - `fwd_valid`, with `fwd_addr` and `fwd_write` equal to the request's address and write flag.
  - `blk_rd_err`.
  - `blk_wr_drop`.
  - With no request, none of the three is raised.
- R7: A blocked read raises `blk_rd_err`, which is the error response. A blocked write raises `blk_wr_drop`. Neither of them is forwarded.
- R8: A block sets the status bit of each window that denied it. The bits are sticky. `irq` is the OR of the status bits. The address of the most recent blocked request is captured at offsets 6 and 7.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When a block and a clear hit the same bit in the same cycle, the bit ends up set.
- R10: A register write takes effect on the following cycle. A request presented in the same cycle as a write is judged against the settings in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Request carries the secure attribute |
| req_cpu | input | 1 | Request originates from the CPU |
| fwd_valid | output | 1 | Allowed request passed on |
| fwd_addr | output | ADDR_W | Address of the passed request |
| fwd_write | output | 1 | Write flag of the passed request |
| blk_rd_err | output | 1 | Blocked read: error response |
| blk_wr_drop | output | 1 | Blocked write: discarded |
| irq | output | 1 | Any status bit set |

## Verification
The assertions take three things for granted about the inputs. A request is one cycle wide and is judged in that same cycle. The register strobe is a single-cycle pulse, with offset and data valid alongside it. Reset holds the block long enough for the status bits to start at zero. The status properties also rely on this: a cleared bit can reappear only when a request was present in the previous cycle. The bench keeps within these assumptions. It drives requests and register writes on the falling edge for exactly one cycle, and it inserts idle cycles where the properties need a quiet previous cycle. When a scenario needs a request and a write to coincide, it presents both in the same cycle.

// File: rtl/carveout_guard.sv
module carveout_guard #(
  parameter int ADDR_W = 40,
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_secure,
  input  logic              req_cpu,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic              fwd_write,
  output logic              blk_rd_err,
  output logic              blk_wr_drop,
  output logic              irq
);
  localparam int CW = 66;
  localparam int MB_SHIFT = 20;

  logic [31:0]       sec_base_q;
  logic [SIZE_W-1:0] sec_size_q;
  logic [31:0]       vid_lo_q, vid_hi_q;
  logic [SIZE_W-1:0] vid_size_q;
  logic [1:0]        stat_q;
  logic [63:0]       fault_q;

  logic [CW-1:0] a_ext, sec_lo, sec_end, vid_lo, vid_end;
  logic sec_hit, vid_hit, sec_deny, vid_deny, deny;
  logic [1:0] clr;

  assign a_ext   = CW'(req_addr);
  assign sec_lo  = CW'(sec_base_q);
  assign sec_end = sec_lo + (CW'(sec_size_q) << MB_SHIFT);
  assign vid_lo  = CW'({vid_hi_q, vid_lo_q});
  assign vid_end = vid_lo + (CW'(vid_size_q) << MB_SHIFT);

  assign sec_hit = (sec_size_q != '0) && (a_ext >= sec_lo) && (a_ext < sec_end);
  assign vid_hit = (vid_size_q != '0) && (a_ext >= vid_lo) && (a_ext < vid_end);

  assign sec_deny = req_valid && sec_hit && !req_secure;
  assign vid_deny = req_valid && vid_hit && req_cpu;
  assign deny     = sec_deny || vid_deny;

  assign clr = (reg_we && reg_addr == 4'd5) ? reg_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_base_q <= '0;
      sec_size_q <= '0;
      vid_lo_q   <= '0;
      vid_hi_q   <= '0;
      vid_size_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        4'd0: sec_base_q <= reg_wdata;
        4'd1: sec_size_q <= reg_wdata[SIZE_W-1:0];
        4'd2: vid_lo_q   <= reg_wdata;
        4'd3: vid_hi_q   <= reg_wdata;
        4'd4: vid_size_q <= reg_wdata[SIZE_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q  <= '0;
      fault_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | {vid_deny, sec_deny};
      if (deny) fault_q <= 64'(req_addr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid   <= 1'b0;
      fwd_addr    <= '0;
      fwd_write   <= 1'b0;
      blk_rd_err  <= 1'b0;
      blk_wr_drop <= 1'b0;
    end else begin
      fwd_valid   <= req_valid && !deny;
      blk_rd_err  <= deny && !req_write;
      blk_wr_drop <= deny && req_write;
      if (req_valid && !deny) begin
        fwd_addr  <= req_addr;
        fwd_write <= req_write;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = sec_base_q;
      4'd1:    reg_rdata = 32'(sec_size_q);
      4'd2:    reg_rdata = vid_lo_q;
      4'd3:    reg_rdata = vid_hi_q;
      4'd4:    reg_rdata = 32'(vid_size_q);
      4'd5:    reg_rdata = {30'b0, stat_q};
      4'd6:    reg_rdata = fault_q[31:0];
      4'd7:    reg_rdata = fault_q[63:32];
      default: reg_rdata = '0;
    endcase
  end

  assign irq = |stat_q;
endmodule

// File: rtl/carveout_guard_chk.sv
module carveout_guard_chk #(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [3:0]        reg_addr,
  input logic [1:0]        reg_wbits,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              req_secure,
  input logic              req_cpu,
  input logic              fwd_valid,
  input logic [ADDR_W-1:0] fwd_addr,
  input logic              fwd_write,
  input logic              blk_rd_err,
  input logic              blk_wr_drop,
  input logic [1:0]        st
);
  a_r6_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> $countones({fwd_valid, blk_rd_err, blk_wr_drop}) == 1);

  a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !fwd_valid && !blk_rd_err && !blk_wr_drop);

  a_r6_fwd_fields: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !fwd_valid || (fwd_addr == $past(req_addr) && fwd_write == $past(req_write)));

  a_r7_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_rd_err || blk_wr_drop) |-> (blk_wr_drop == $past(req_write)));

  a_r4_sec_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (st[0] && !$past(st[0])) |-> $past(req_valid && !req_secure));

  a_r5_vid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (st[1] && !$past(st[1])) |-> $past(req_valid && req_cpu));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st[0]) && !st[0]) |-> $past(reg_we && reg_addr == 4'd5 && reg_wbits[0]));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd5 && reg_wbits[1] && !req_valid) |=> !st[1]);
endmodule

bind carveout_guard carveout_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wbits(reg_wdata[1:0]), .req_valid(req_valid), .req_addr(req_addr),
  .req_write(req_write), .req_secure(req_secure), .req_cpu(req_cpu),
  .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_write(fwd_write),
  .blk_rd_err(blk_rd_err), .blk_wr_drop(blk_wr_drop), .st(stat_q)
);

// File: tb/sim_carveout_guard.sv
`timescale 1ns/1ps
module sim_carveout_guard;
  localparam int AW = 40;
  localparam int SW = 12;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic req_valid = 0, req_write = 0, req_secure = 0, req_cpu = 0;
  logic [AW-1:0] req_addr = 0, fwd_addr;
  logic fwd_valid, fwd_write, blk_rd_err, blk_wr_drop, irq;

  int n_chk = 0, n_err = 0;

  // shadow model
  logic [31:0] m_sbase = 0, m_vlo = 0, m_vhi = 0;
  logic [SW-1:0] m_ssize = 0, m_vsize = 0;
  logic [1:0] m_st = 0;
  logic [63:0] m_fault = 0;

  carveout_guard #(.ADDR_W(AW), .SIZE_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .req_secure(req_secure),
    .req_cpu(req_cpu), .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
    .fwd_write(fwd_write), .blk_rd_err(blk_rd_err), .blk_wr_drop(blk_wr_drop),
    .irq(irq));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit inwin(logic [63:0] base, logic [SW-1:0] mb, logic [AW-1:0] a);
    logic [67:0] lo, hi, x;
    lo = 68'(base);
    hi = lo + 68'(mb) * 68'h100000;
    x = 68'(a);
    return (mb != 0) && (x >= lo) && (x < hi);
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    case (a)
      4'd0: m_sbase = d;
      4'd1: m_ssize = d[SW-1:0];
      4'd2: m_vlo = d;
      4'd3: m_vhi = d;
      4'd4: m_vsize = d[SW-1:0];
      4'd5: m_st = m_st & ~d[1:0];
      default: ;
    endcase
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic model_req(input logic [AW-1:0] a, input bit w, input bit s, input bit c,
                           output bit blk);
    bit sd, vd;
    sd = inwin(64'(m_sbase), m_ssize, a) && !s;
    vd = inwin({m_vhi, m_vlo}, m_vsize, a) && c;
    blk = sd || vd;
    m_st = m_st | {vd, sd};
    if (blk) m_fault = 64'(a);
  endtask

  task automatic check_out(input string tag, input logic [AW-1:0] a, input bit w, input bit blk);
    chk({tag, " fwd_valid"}, fwd_valid, !blk);
    chk({tag, " blk_rd_err"}, blk_rd_err, blk && !w);
    chk({tag, " blk_wr_drop"}, blk_wr_drop, blk && w);
    if (!blk) begin
      chk({tag, " fwd_addr"}, fwd_addr, a);
      chk({tag, " fwd_write"}, fwd_write, w);
    end
  endtask

  task automatic req(input string tag, input logic [AW-1:0] a, input bit w, input bit s, input bit c);
    bit blk;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w; req_secure = s; req_cpu = c;
    model_req(a, w, s, c, blk);
    @(negedge clk);
    req_valid = 0;
    check_out(tag, a, w, blk);
  endtask

  task automatic check_status(input string tag);
    logic [31:0] d;
    rd(4'd5, d); chk({tag, " status"}, d, 32'(m_st));
    rd(4'd6, d); chk({tag, " fault_lo"}, d, m_fault[31:0]);
    rd(4'd7, d); chk({tag, " fault_hi"}, d, m_fault[63:32]);
    chk({tag, " irq"}, irq, |m_st);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), d);
      chk("R1 reg after reset", d, 0);
    end
    chk("R1 irq", irq, 0);
    chk("R1 fwd_valid", fwd_valid, 0);
    chk("R1 blk_rd_err", blk_rd_err, 0);
    chk("R1 blk_wr_drop", blk_wr_drop, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(4'd0, 32'h4000_0000);
    wr(4'd1, 32'hFFFF_F010);
    wr(4'd2, 32'h8000_0000);
    wr(4'd3, 32'h0000_0001);
    wr(4'd4, 32'h0000_0002);
    wr(4'd9, 32'hDEAD_BEEF);
    rd(4'd0, d); chk("R2 sec base", d, 32'h4000_0000);
    rd(4'd1, d); chk("R2 sec size masked", d, 32'h010);
    rd(4'd2, d); chk("R2 vid lo", d, 32'h8000_0000);
    rd(4'd3, d); chk("R2 vid hi", d, 32'h1);
    rd(4'd4, d); chk("R2 vid size", d, 32'h2);
    rd(4'd9, d); chk("R2 unused offset", d, 0);
    rd(4'd15, d); chk("R2 top offset", d, 0);
  endtask

  task automatic t_secure;
    req("R3 R4 below base", 40'h003F_FF_FFFF, 0, 0, 0);
    req("R3 R4 at base nonsec read", 40'h0040_0000_00, 0, 0, 0);
    req("R4 inside secure read", 40'h0040_0000_00, 0, 1, 0);
    req("R3 R4 last byte nonsec write", 40'h0040_FF_FFFF, 1, 0, 1);
    req("R3 end excluded", 40'h0041_0000_00, 0, 0, 0);
    req("R4 secure cpu write inside", 40'h0040_8000_00, 1, 1, 1);
    check_status("R8 after secure");
  endtask

  task automatic t_video;
    req("R5 vid cpu read at base", 40'h01_8000_0000, 0, 1, 1);
    req("R5 R7 vid cpu write", 40'h01_801F_FFFF, 1, 1, 1);
    req("R5 vid noncpu write", 40'h01_8010_0000, 1, 0, 0);
    req("R3 R5 vid end excluded", 40'h01_8020_0000, 0, 1, 1);
    req("R5 hi word matters", 40'h00_8000_0000, 0, 1, 1);
    check_status("R8 after video");
  endtask

  task automatic t_clear;
    logic [31:0] d;
    bit blk;
    wr(4'd5, 32'h0000_0001);
    check_status("R9 clear bit0 only");
    wr(4'd5, 32'h0000_0000);
    check_status("R9 zero write no effect");
    wr(4'd5, 32'h0000_0002);
    check_status("R9 clear bit1");
    // set wins over clear in the same cycle
    @(negedge clk);
    reg_we = 1; reg_addr = 4'd5; reg_wdata = 32'h3;
    req_valid = 1; req_addr = 40'h0040_0010_00; req_write = 0; req_secure = 0; req_cpu = 0;
    m_st = 0;
    model_req(req_addr, 0, 0, 0, blk);
    @(negedge clk);
    reg_we = 0; req_valid = 0;
    check_out("R9 set wins", 40'h0040_0010_00, 0, blk);
    rd(4'd5, d); chk("R9 set wins status", d, 32'h1);
    wr(4'd5, 32'h3);
  endtask

  task automatic t_same_cycle;
    bit blk;
    @(negedge clk);
    reg_we = 1; reg_addr = 4'd1; reg_wdata = 32'h0;
    req_valid = 1; req_addr = 40'h0040_0020_00; req_write = 1; req_secure = 0; req_cpu = 0;
    model_req(req_addr, 1, 0, 0, blk);
    m_ssize = 0;
    @(negedge clk);
    reg_we = 0; req_valid = 0;
    check_out("R10 old setting applied", 40'h0040_0020_00, 1, blk);
    chk("R10 expected block", blk, 1);
    req("R10 R3 size zero disables", 40'h0040_0020_00, 1, 0, 0);
    wr(4'd5, 32'h3);
  endtask

  task automatic t_overlap;
    wr(4'd1, 32'h10);
    wr(4'd3, 32'h0);
    wr(4'd2, 32'h4080_0000);
    wr(4'd4, 32'h1);
    req("R8 both windows", 40'h0040_8400_00, 0, 0, 1);
    check_status("R8 both bits");
    req("R4 R5 secure noncpu overlap passes", 40'h0040_8400_00, 0, 1, 0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk("R6 idle fwd", fwd_valid, 0);
    chk("R6 idle rd err", blk_rd_err, 0);
    chk("R6 idle wr drop", blk_wr_drop, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R6 watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_secure();
    t_video();
    t_clear();
    t_same_cycle();
    t_overlap();
    t_idle();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule